// File: doc/BRIEF.md
# Translation lookaside buffer

This block is a small, fully associative store of recent translations from virtual page to page entry, placed in front of a page table walker. A lookup presents a 48-bit virtual address, an access type and a privilege bit. In the same cycle the upper 36 bits, the virtual page number, are compared with every live entry. A match that the stored flags permit gives a physical address: the stored physical page number above the untouched 12-bit page offset. A match that the flags forbid reports a protection fault instead.

A lookup that matches nothing reports a miss and starts the walker. A small controller has two states. In `WK_IDLE` a miss raises a one-cycle `walk_start` and takes the transition *start* to `WK_WAIT`. In `WK_WAIT`, `walk_busy` is high and further misses start nothing. A `fill_valid` pulse takes the transition *done* back to `WK_IDLE`. The fill writes the page number, physical page number, flags and a global bit into one entry. On a context switch, `flush_user` clears every entry that is not global, so kernel mappings survive. `flush_all` clears every entry.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and `walk_busy` and `walk_start` are 0.
- R2: A lookup that matches a valid entry and is permitted raises `lk_hit` combinationally, with `lk_paddr` = {stored physical page number, `lk_vaddr[11:0]`}. The key is `lk_vaddr[47:12]`.
- R3: The access code `lk_acc` is 0 read, 1 write, 2 fetch and 3 reserved. Flag bit 0 allows write, bit 1 allows fetch and bit 2 allows user access. A matching lookup raises `lk_fault` and no `lk_hit` when any of these holds: the access is a write and bit 0 is clear; the access is a fetch and bit 1 is clear; `lk_user`=1 and bit 2 is clear; or the code is 3.
- R4: In `WK_IDLE`, a lookup that misses raises `walk_start` in that cycle with `walk_vpn` = `lk_vaddr[47:12]`. From the next cycle `walk_busy` is 1 and `walk_start` stays 0 until a cycle with `fill_valid`, after which `walk_busy` returns to 0.
- R5: A fill takes effect at the next clock edge. From then on, a lookup of the filled page number matches.
- R6: A fill whose page number is already valid overwrites that entry. It creates no second copy.
- R7: A fill writes the lowest-indexed invalid entry. When all 8 entries are valid, it evicts the entry at a round-robin pointer. The pointer starts at 0 and advances by one on each eviction.
- R8: `flush_user` invalidates every entry whose global bit is 0 at the next edge and keeps the global ones.
- R9: `flush_all` invalidates every entry at the next edge and returns the round-robin pointer to 0.
- R10: A flush in the same cycle as a fill has priority: the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lk_user | input | 1 | 1 when the access comes from user mode |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No valid entry matches |
| lk_fault | output | 1 | Entry matches but the access is forbidden |
| lk_paddr | output | 40 | Physical address, meaningful with `lk_hit` |
| walk_start | output | 1 | Starts a walk for `walk_vpn` |
| walk_vpn | output | 36 | Page number the walker must resolve |
| walk_busy | output | 1 | A walk is outstanding |
| fill_valid | input | 1 | Walker result is present |
| fill_vpn | input | 36 | Virtual page number of the result |
| fill_ppn | input | 28 | Physical page number of the result |
| fill_flags | input | 3 | Permission flags of the result |
| fill_global | input | 1 | Entry belongs to the kernel half and survives a user flush |
| flush_user | input | 1 | Invalidate non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
Fill and flush can fall in the same cycle, and that is the case most exposed to wrong ordering. The bench holds `fill_valid` high with a new page in the same clock as `flush_user`, while a global entry is already stored. Lookups afterwards must miss the new page and still hit the global one. Duplicate fills and the choice of victim are judged by the physical address returned, or by which earlier pages miss after a following fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int FLAG_W = 3;
    localparam int FL_WR  = 0;
    localparam int FL_EX  = 1;
    localparam int FL_USR = 2;

    typedef enum logic {
        WK_IDLE,
        WK_WAIT
    } wk_state_e;

    function automatic logic perm_ok(input logic [FLAG_W-1:0] fl,
                                     input logic [1:0]        acc,
                                     input logic              usr);
        logic ok;
        ok = 1'b1;
        if (acc == ACC_WRITE && !fl[FL_WR]) ok = 1'b0;
        if (acc == ACC_FETCH && !fl[FL_EX]) ok = 1'b0;
        if (acc == ACC_RSVD)                ok = 1'b0;
        if (usr && !fl[FL_USR])             ok = 1'b0;
        return ok;
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 8,
    parameter int TAG_W = 36
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tags[i] == key);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vld,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output logic             full
);
    always_comb begin
        full = &vld;
        slot = rr_ptr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) slot = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss,
    input  logic fill_valid,
    output logic walk_start,
    output logic walk_busy
);
    wk_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WK_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WK_IDLE: if (miss)       state_nx = WK_WAIT;
            WK_WAIT: if (fill_valid) state_nx = WK_IDLE;
            default:                 state_nx = WK_IDLE;
        endcase
    end

    always_comb begin
        walk_start = 1'b0;
        walk_busy  = 1'b0;
        unique case (state)
            WK_IDLE: walk_start = miss;
            WK_WAIT: walk_busy  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 28,
    parameter int ENTRIES = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [1:0]         lk_acc,
    input  logic               lk_user,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic               lk_fault,
    output logic [PA_W-1:0]    lk_paddr,
    output logic               walk_start,
    output logic [VPN_W-1:0]   walk_vpn,
    output logic               walk_busy,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic [FLAG_W-1:0]  fill_flags,
    input  logic               fill_global,
    input  logic               flush_user,
    input  logic               flush_all
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             ent_vld, ent_glb;
    logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
    logic [ENTRIES-1:0][FLAG_W-1:0] ent_flg;
    logic [IDX_W-1:0]               rr_ptr;

    logic [VPN_W-1:0]  lk_vpn;
    logic [ENTRIES-1:0] lk_hv, fill_hv;
    logic [PPN_W-1:0]  sel_ppn;
    logic [FLAG_W-1:0] sel_flg;
    logic              lk_any, lk_ok;
    logic [IDX_W-1:0]  vic_slot, dup_slot, tgt;
    logic              vic_full, fill_dup, fill_take, evict;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
        .vld(ent_vld), .tags(ent_vpn), .key(lk_vpn), .hit(lk_hv)
    );

    tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill_match (
        .vld(ent_vld), .tags(ent_vpn), .key(fill_vpn), .hit(fill_hv)
    );

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .vld(ent_vld), .rr_ptr(rr_ptr), .slot(vic_slot), .full(vic_full)
    );

    // OR-mux: matching entries are unique because fills deduplicate
    always_comb begin
        sel_ppn  = '0;
        sel_flg  = '0;
        dup_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hv[i]) begin
                sel_ppn = sel_ppn | ent_ppn[i];
                sel_flg = sel_flg | ent_flg[i];
            end
            if (fill_hv[i]) dup_slot = IDX_W'(i);
        end
    end

    assign lk_any   = |lk_hv;
    assign lk_ok    = perm_ok(sel_flg, lk_acc, lk_user);
    assign lk_miss  = lk_valid && !lk_any;
    assign lk_hit   = lk_valid && lk_any && lk_ok;
    assign lk_fault = lk_valid && lk_any && !lk_ok;
    assign lk_paddr = {sel_ppn, lk_vaddr[OFF_W-1:0]};
    assign walk_vpn = lk_vpn;

    assign fill_dup  = |fill_hv;
    assign fill_take = fill_valid && !flush_user && !flush_all;
    assign tgt       = fill_dup ? dup_slot : vic_slot;
    assign evict     = fill_take && !fill_dup && vic_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_glb <= '0;
            rr_ptr  <= '0;
        end else if (flush_all) begin
            ent_vld <= '0;
            rr_ptr  <= '0;
        end else if (flush_user) begin
            ent_vld <= ent_vld & ent_glb;
        end else if (fill_take) begin
            ent_vld[tgt] <= 1'b1;
            ent_glb[tgt] <= fill_global;
            if (evict) begin
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_take) begin
            ent_vpn[tgt] <= fill_vpn;
            ent_ppn[tgt] <= fill_ppn;
            ent_flg[tgt] <= fill_flags;
        end
    end

    tlb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .miss(lk_miss), .fill_valid(fill_valid),
        .walk_start(walk_start), .walk_busy(walk_busy)
    );
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
    parameter int VA_W  = 48,
    parameter int OFF_W = 12,
    parameter int PPN_W = 28,
    parameter int VPN_W = 36,
    parameter int PA_W  = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             walk_start,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             walk_busy,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic             flush_user,
    input logic             flush_all
);
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lk_hit, lk_miss, lk_fault}) == (lk_valid ? 1 : 0));

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    p_start_then_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> walk_busy);

    p_no_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy |-> !walk_start);

    p_fill_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && fill_valid) |=> !walk_busy);

    p_start_vpn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |-> walk_vpn == lk_vaddr[VA_W-1:OFF_W]);

    p_flush_all_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !(lk_hit || lk_fault));

    p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_valid && !flush_user && !flush_all) && $past(rst_n) && lk_valid
         && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |-> !lk_miss);
endmodule

bind tlb_cache tlb_cache_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .VPN_W(VPN_W), .PA_W(PA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .walk_start(walk_start), .walk_vpn(walk_vpn), .walk_busy(walk_busy),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .flush_user(flush_user), .flush_all(flush_all)
);

// File: tb/tlb_cache_test.sv
module tlb_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = 2'd0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_miss, lk_fault, walk_start, walk_busy;
    logic [39:0] lk_paddr;
    logic [35:0] walk_vpn;
    logic        fill_valid = 1'b0;
    logic [35:0] fill_vpn = '0;
    logic [27:0] fill_ppn = '0;
    logic [2:0]  fill_flags = '0;
    logic        fill_global = 1'b0;
    logic        flush_user = 1'b0;
    logic        flush_all = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic r_hit, r_miss, r_fault;
    logic [39:0] r_pa;

    always #5 clk = ~clk;

    tlb_cache uut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [47:0] va, input logic [1:0] acc, input logic usr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = usr;
        #1;
        r_hit = lk_hit; r_miss = lk_miss; r_fault = lk_fault; r_pa = lk_paddr;
        #1;
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [35:0] v, input logic [27:0] p,
                        input logic [2:0] fl, input logic g);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_flags = fl; fill_global = g;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic flush(input logic usr_only);
        @(negedge clk);
        if (usr_only) flush_user = 1'b1; else flush_all = 1'b1;
        @(negedge clk);
        flush_user = 1'b0; flush_all = 1'b0;
    endtask

    task automatic present(input string tag, input logic [35:0] v, input logic exp);
        look({v, 12'h010}, 2'd0, 1'b0);
        check(tag, {63'd0, r_hit}, {63'd0, exp});
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        check("R1 walk_busy after reset", {63'd0, walk_busy}, 64'd0);
        check("R1 walk_start idle", {63'd0, walk_start}, 64'd0);
        look(48'h0000_0000_1000, 2'd0, 1'b0);
        check("R1 lookup misses after reset", {63'd0, r_miss}, 64'd1);
    endtask

    task automatic t_miss_walk;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = 48'h1234_5678_9ABC; lk_acc = 2'd0; lk_user = 1'b0;
        #1;
        check("R4 miss reported", {63'd0, lk_miss}, 64'd1);
        check("R4 walk_start on miss", {63'd0, walk_start}, 64'd1);
        check("R4 walk_vpn", {28'd0, walk_vpn}, {28'd0, 36'h1_2345_6789});
        @(negedge clk);
        #1;
        check("R4 busy after start", {63'd0, walk_busy}, 64'd1);
        check("R4 no restart while busy", {63'd0, walk_start}, 64'd0);
        lk_valid = 1'b0;
        fill(36'h1_2345_6789, 28'h0AB_CDEF, 3'b111, 1'b0);
        #1;
        check("R4 busy cleared by fill", {63'd0, walk_busy}, 64'd0);
        look(48'h1234_5678_9ABC, 2'd0, 1'b1);
        check("R5 filled page hits", {63'd0, r_hit}, 64'd1);
        check("R5 filled paddr", {24'd0, r_pa}, {24'd0, 28'h0AB_CDEF, 12'hABC});
    endtask

    task automatic t_hit_translate;
        fill(36'h0_ABCD_1234, 28'h55A_A55, 3'b111, 1'b0);
        look({36'h0_ABCD_1234, 12'h3C7}, 2'd0, 1'b1);
        check("R2 hit", {63'd0, r_hit}, 64'd1);
        check("R2 paddr mid offset", {24'd0, r_pa}, {24'd0, 28'h55A_A55, 12'h3C7});
        look({36'h0_ABCD_1234, 12'hFFF}, 2'd1, 1'b0);
        check("R2 paddr top offset", {24'd0, r_pa}, {24'd0, 28'h55A_A55, 12'hFFF});
        look({36'h0_ABCD_1234, 12'h000}, 2'd2, 1'b1);
        check("R2 paddr zero offset fetch", {24'd0, r_pa}, {24'd0, 28'h55A_A55, 12'h000});
    endtask

    task automatic t_perm;
        fill(36'h0_0000_0777, 28'h111_1111, 3'b000, 1'b1);
        look({36'h0_0000_0777, 12'h004}, 2'd0, 1'b0);
        check("R3 kernel read allowed", {62'd0, r_hit, r_fault}, 64'd2);
        look({36'h0_0000_0777, 12'h004}, 2'd1, 1'b0);
        check("R3 write to read-only faults", {62'd0, r_hit, r_fault}, 64'd1);
        look({36'h0_0000_0777, 12'h004}, 2'd2, 1'b0);
        check("R3 fetch from no-exec faults", {62'd0, r_hit, r_fault}, 64'd1);
        look({36'h0_0000_0777, 12'h004}, 2'd0, 1'b1);
        check("R3 user read of kernel page faults", {62'd0, r_hit, r_fault}, 64'd1);
        look({36'h0_0000_0777, 12'h004}, 2'd3, 1'b0);
        check("R3 reserved code faults", {62'd0, r_hit, r_fault}, 64'd1);
    endtask

    task automatic t_dup_fill;
        flush(1'b0);
        fill(36'h0_0000_0ABC, 28'h000_000F, 3'b111, 1'b0);
        fill(36'h0_0000_0ABC, 28'h000_00F0, 3'b111, 1'b0);
        look({36'h0_0000_0ABC, 12'h000}, 2'd0, 1'b0);
        check("R6 duplicate fill overwrites", {24'd0, r_pa}, {24'd0, 28'h000_00F0, 12'h000});
    endtask

    task automatic t_replace;
        flush(1'b0);
        for (int i = 0; i < 8; i++) fill(36'h100 + 36'(i), 28'(i), 3'b111, 1'b0);
        fill(36'h200, 28'h20, 3'b111, 1'b0);
        present("R7 first eviction takes slot 0", 36'h100, 1'b0);
        present("R7 slot 1 survives first eviction", 36'h101, 1'b1);
        fill(36'h201, 28'h21, 3'b111, 1'b0);
        present("R7 second eviction takes slot 1", 36'h101, 1'b0);
        present("R7 slot 2 survives", 36'h102, 1'b1);
        present("R7 new entry kept", 36'h200, 1'b1);
    endtask

    task automatic t_flush_user;
        flush(1'b0);
        for (int i = 0; i < 8; i++) fill(36'h300 + 36'(i), 28'(i), 3'b111, (i != 2));
        flush(1'b1);
        present("R8 user entry cleared", 36'h302, 1'b0);
        present("R8 global entry kept", 36'h305, 1'b1);
        present("R8 global entry 0 kept", 36'h300, 1'b1);
        fill(36'h3FF, 28'h3F, 3'b111, 1'b0);
        present("R7 invalid slot preferred, slot 0 kept", 36'h300, 1'b1);
        fill(36'h400, 28'h40, 3'b111, 1'b0);
        present("R7 pointer still at 0", 36'h300, 1'b0);
        present("R7 refilled slot kept", 36'h3FF, 1'b1);
    endtask

    task automatic t_flush_all;
        fill(36'h500, 28'h50, 3'b111, 1'b1);
        present("R9 global present before flush", 36'h500, 1'b1);
        flush(1'b0);
        present("R9 global cleared by full flush", 36'h500, 1'b0);
    endtask

    task automatic t_flush_vs_fill;
        fill(36'h600, 28'h60, 3'b111, 1'b1);
        @(negedge clk);
        flush_user = 1'b1;
        fill_valid = 1'b1; fill_vpn = 36'h601; fill_ppn = 28'h61;
        fill_flags = 3'b111; fill_global = 1'b0;
        @(negedge clk);
        flush_user = 1'b0; fill_valid = 1'b0;
        present("R10 fill dropped under flush", 36'h601, 1'b0);
        present("R10 global kept through flush", 36'h600, 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_walk();
        t_hit_translate();
        t_perm();
        t_dup_fill();
        t_replace();
        t_flush_user();
        t_flush_all();
        t_flush_vs_fill();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule